// File: doc/BRIEF.md
# Physical Register Ready Scoreboard

This block holds one ready flag per physical register of an out-of-order core. The flat index space starts with the integer physical registers. The floating-point physical registers follow, and a miscellaneous region with a fixed number of entries per thread comes last. The back end of the core uses it in three ways. It raises a flag when a result is written back, it drops a flag when rename hands the register out as a new destination, and it asks two read ports whether source operands are available.

A synchronous reset loads a ready pattern that depends on the number of active threads, sampled from an input while reset is held. The architectural mappings of each active thread start out ready, and so do the miscellaneous entries that belong to active threads. One integer register and one floating-point register are hard-wired zero registers. These two always report ready, whatever their stored flag says.

Top module: `preg_ready_sb`

## Requirements
- R1: The valid index range is 0 up to P_INT + P_FP + MISC × T − 1, where T is the latched active thread count. Integer entries occupy [0, P_INT), floating-point entries occupy [P_INT, P_INT+P_FP), and the miscellaneous region starts at P_INT+P_FP.
- R2: After reset, integer indices below L_INT × T read ready, and the remaining integer indices read not ready.
- R3: After reset, floating-point indices from P_INT up to P_INT + L_FP × T − 1 read ready, and the rest of the floating-point region reads not ready.
- R4: After reset, every miscellaneous index of an active thread reads ready.
- R5: `threads_i` is sampled only in cycles where `rst` is high. A value of 0 is taken as 1 and a value above MAX_THREADS is taken as MAX_THREADS. Changes while `rst` is low have no effect.
- R6: A read of index ZERO_IDX or ZERO_IDX + P_INT returns 1, even after a clear to that index.
- R7: A set request (`set_en`=1) to a valid index makes that index read 1 from the next cycle on.
- R8: A clear request (`clr_en`=1) to a valid index makes that index read 0 from the next cycle on.
- R9: When set and clear name the same valid index in one cycle, the index ends up 0.
- R10: Read results appear one clock after the index is presented. They reflect the flags as they stood before that cycle's updates, and they are 0 in the cycle after a reset cycle.
- R11: Indices at or beyond the valid length are ignored by set and clear and read as 0.
- R12: The two read ports work independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the ready pattern |
| threads_i | input | $clog2(MAX_THREADS+1) | Active thread count, sampled during reset |
| rd_a_idx | input | $clog2(LEN) | Read port A index |
| rd_a_rdy | output | 1 | Read port A ready flag, registered |
| rd_b_idx | input | $clog2(LEN) | Read port B index |
| rd_b_rdy | output | 1 | Read port B ready flag, registered |
| set_en | input | 1 | Mark-ready request (writeback) |
| set_idx | input | $clog2(LEN) | Index to mark ready |
| clr_en | input | 1 | Mark-not-ready request (destination allocation) |
| clr_idx | input | $clog2(LEN) | Index to mark not ready |

## Verification
The bench builds the block with P_INT=12, P_FP=10, L_INT=4, L_FP=3, MISC=2, MAX_THREADS=3 and ZERO_IDX=2. This gives 28 entries behind a 5-bit index. Indices 28 to 31 are therefore always out of range. With one thread the last miscellaneous entries also fall out of range, so the length that moves with the thread count can be observed at the read ports. With three threads the integer architectural region fills the integer file exactly, which exercises the edge of the reset ranges. The small sizes also let a sweep after each reset visit every index, including both zero registers, between the random set and clear traffic.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Bring a requested thread count into the legal range 1..maxv.
  function automatic int sb_clamp(input int req, input int maxv);
    if (req < 1) return 1;
    if (req > maxv) return maxv;
    return req;
  endfunction

endpackage

// File: rtl/sb_reset_map.sv
module sb_reset_map
  import sb_pkg::*;
#(
  parameter int P_INT       = 40,
  parameter int P_FP        = 40,
  parameter int L_INT       = 16,
  parameter int L_FP        = 16,
  parameter int MISC        = 4,
  parameter int MAX_THREADS = 2,
  parameter int TW          = 2,
  parameter int LEN         = 88,
  parameter int CW          = 8
) (
  input  logic [TW-1:0]  thr,
  output logic [LEN-1:0] pattern,
  output logic [CW-1:0]  valid_len
);

  logic [CW-1:0] t_c;
  logic [CW-1:0] int_end;
  logic [CW-1:0] fp_end;
  logic [CW-1:0] misc_end;

  always_comb begin
    t_c      = CW'(sb_clamp(int'(thr), MAX_THREADS));
    int_end  = CW'(L_INT) * t_c;
    fp_end   = CW'(P_INT) + CW'(L_FP) * t_c;
    misc_end = CW'(P_INT + P_FP) + CW'(MISC) * t_c;
  end

  assign valid_len = misc_end;

  // One comparator per entry, chosen by the region the entry sits in.
  for (genvar i = 0; i < LEN; i++) begin : g_ent
    localparam logic [CW-1:0] IDX = CW'(i);
    if (i < P_INT) begin : g_int
      assign pattern[i] = (IDX < int_end);
    end else if (i < P_INT + P_FP) begin : g_fp
      assign pattern[i] = (IDX < fp_end);
    end else begin : g_misc
      assign pattern[i] = (IDX < misc_end);
    end
  end

endmodule

// File: rtl/sb_store.sv
module sb_store #(
  parameter int LEN = 88,
  parameter int IW  = 7,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LEN-1:0] load_pat,
  input  logic [CW-1:0]  valid_len,
  input  logic           set_en,
  input  logic [IW-1:0]  set_idx,
  input  logic           clr_en,
  input  logic [IW-1:0]  clr_idx,
  output logic [LEN-1:0] bits
);

  logic set_ok;
  logic clr_ok;

  assign set_ok = set_en && (CW'(set_idx) < valid_len);
  assign clr_ok = clr_en && (CW'(clr_idx) < valid_len);

  // Clear is applied after set so that it wins on a shared index.
  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= load_pat;
    end else begin
      if (set_ok) bits[set_idx] <= 1'b1;
      if (clr_ok) bits[clr_idx] <= 1'b0;
    end
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (set_ok && !(clr_ok && clr_idx == set_idx)) |=> bits[$past(set_idx)]); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    clr_ok |=> !bits[$past(clr_idx)]); // R8

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_ok && clr_ok && set_idx == clr_idx) |=> !bits[$past(set_idx)]); // R9

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!set_ok && !clr_ok) |=> $stable(bits)); // R11

endmodule

// File: rtl/sb_read_port.sv
module sb_read_port #(
  parameter int LEN    = 88,
  parameter int IW     = 7,
  parameter int CW     = 8,
  parameter int ZERO_A = 15,
  parameter int ZERO_B = 55
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LEN-1:0] bits,
  input  logic [CW-1:0]  valid_len,
  input  logic [IW-1:0]  idx,
  output logic           rdy
);

  localparam logic [CW-1:0] ZA = CW'(ZERO_A);
  localparam logic [CW-1:0] ZB = CW'(ZERO_B);

  logic [CW-1:0] idx_w;
  logic          in_rng;
  logic          is_zero;
  logic          stored;

  always_comb begin
    idx_w   = CW'(idx);
    in_rng  = (idx_w < valid_len);
    is_zero = (idx_w == ZA) || (idx_w == ZB);
    stored  = in_rng ? bits[idx] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdy <= 1'b0;
    else     rdy <= in_rng && (is_zero || stored);
  end

  AST_ZERO_READY: assert property (@(posedge clk) disable iff (rst)
    (idx_w == ZA || idx_w == ZB) |=> rdy); // R6

  AST_OOR_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (idx_w >= valid_len) |=> !rdy); // R11

endmodule

// File: rtl/preg_ready_sb.sv
module preg_ready_sb
  import sb_pkg::*;
#(
  parameter int P_INT       = 40,
  parameter int P_FP        = 40,
  parameter int L_INT       = 16,
  parameter int L_FP        = 16,
  parameter int MISC        = 4,
  parameter int MAX_THREADS = 2,
  parameter int ZERO_IDX    = 15,
  localparam int LEN        = P_INT + P_FP + MISC * MAX_THREADS,
  localparam int IW         = $clog2(LEN),
  localparam int TW         = $clog2(MAX_THREADS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] threads_i,
  input  logic [IW-1:0] rd_a_idx,
  output logic          rd_a_rdy,
  input  logic [IW-1:0] rd_b_idx,
  output logic          rd_b_rdy,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx
);

  localparam int CW = $clog2(LEN + 1) + 1;

  logic [LEN-1:0] pat;
  logic [CW-1:0]  pat_len;
  logic [CW-1:0]  len_q;
  logic [LEN-1:0] bits;
  logic [IW-1:0]  rd_idx [2];
  logic           rd_rdy [2];

  sb_reset_map #(
    .P_INT(P_INT), .P_FP(P_FP), .L_INT(L_INT), .L_FP(L_FP), .MISC(MISC),
    .MAX_THREADS(MAX_THREADS), .TW(TW), .LEN(LEN), .CW(CW)
  ) u_map (
    .thr       (threads_i),
    .pattern   (pat),
    .valid_len (pat_len)
  );

  // Active length is fixed at reset time and held until the next reset.
  always_ff @(posedge clk) begin
    if (rst) len_q <= pat_len;
  end

  sb_store #(.LEN(LEN), .IW(IW), .CW(CW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .load_pat  (pat),
    .valid_len (len_q),
    .set_en    (set_en),
    .set_idx   (set_idx),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .bits      (bits)
  );

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    sb_read_port #(
      .LEN(LEN), .IW(IW), .CW(CW),
      .ZERO_A(ZERO_IDX), .ZERO_B(ZERO_IDX + P_INT)
    ) u_rd (
      .clk       (clk),
      .rst       (rst),
      .bits      (bits),
      .valid_len (len_q),
      .idx       (rd_idx[p]),
      .rdy       (rd_rdy[p])
    );
  end

  assign rd_a_rdy = rd_rdy[0];
  assign rd_b_rdy = rd_rdy[1];

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(len_q)); // R5

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (len_q <= CW'(LEN) && len_q >= CW'(P_INT + P_FP + MISC))); // R1

endmodule

// File: tb/sim_preg_ready_sb.sv
module sim_preg_ready_sb;

  localparam int P_INT = 12, P_FP = 10, L_INT = 4, L_FP = 3, MISC = 2;
  localparam int MAXT = 3, ZI = 2;
  localparam int LEN = P_INT + P_FP + MISC * MAXT;
  localparam int IW = $clog2(LEN);
  localparam int TW = $clog2(MAXT + 1);
  localparam int NIDX = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] threads_i = '0;
  logic [IW-1:0] rd_a_idx = '0, rd_b_idx = '0, set_idx = '0, clr_idx = '0;
  logic set_en = 1'b0, clr_en = 1'b0;
  logic rd_a_rdy, rd_b_rdy;

  always #4 clk = ~clk;

  preg_ready_sb #(
    .P_INT(P_INT), .P_FP(P_FP), .L_INT(L_INT), .L_FP(L_FP), .MISC(MISC),
    .MAX_THREADS(MAXT), .ZERO_IDX(ZI)
  ) u0 (
    .clk(clk), .rst(rst), .threads_i(threads_i),
    .rd_a_idx(rd_a_idx), .rd_a_rdy(rd_a_rdy),
    .rd_b_idx(rd_b_idx), .rd_b_rdy(rd_b_rdy),
    .set_en(set_en), .set_idx(set_idx), .clr_en(clr_en), .clr_idx(clr_idx)
  );

  int checks = 0, failures = 0;
  bit mref [LEN];
  int mlen = 0;
  int cur_th = 2;

  function automatic int clampt(input int t);
    if (t < 1) return 1;
    if (t > MAXT) return MAXT;
    return t;
  endfunction

  function automatic bit pat_of(input int t, input int i);
    if (i < P_INT) return i < L_INT * t;
    if (i < P_INT + P_FP) return i < P_INT + L_FP * t;
    return i < P_INT + P_FP + MISC * t;
  endfunction

  function automatic bit exp_rd(input int i);
    if (i >= mlen) return 1'b0;
    if (i == ZI || i == ZI + P_INT) return 1'b1;
    return mref[i];
  endfunction

  function automatic string tag_of(input int i);
    if (i == ZI || i == ZI + P_INT) return "R6";
    if (i >= mlen) return "R11";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, predict from the model, check at next negedge.
  task automatic cyc(input bit r, input int th, input int ai, input int bi,
                     input bit se, input int si, input bit ce, input int ci,
                     input string ta, input string tb);
    bit ea, eb;
    rst = r; threads_i = TW'(th);
    rd_a_idx = IW'(ai); rd_b_idx = IW'(bi);
    set_en = se; set_idx = IW'(si); clr_en = ce; clr_idx = IW'(ci);
    ea = r ? 1'b0 : exp_rd(ai);
    eb = r ? 1'b0 : exp_rd(bi);
    @(posedge clk);
    if (r) begin
      mlen = P_INT + P_FP + MISC * clampt(th);
      for (int i = 0; i < LEN; i++) mref[i] = pat_of(clampt(th), i);
    end else begin
      if (se && si < mlen) mref[si] = 1'b1;
      if (ce && ci < mlen) mref[ci] = 1'b0;
    end
    @(negedge clk);
    chk(ta, rd_a_rdy, ea);
    chk(tb, rd_b_rdy, eb);
  endtask

  task automatic rd(input int ai, input int bi, input string ta, input string tb);
    cyc(1'b0, cur_th, ai, bi, 1'b0, 0, 1'b0, 0, ta, tb);
  endtask

  task automatic do_reset(input int th);
    cur_th = th;
    cyc(1'b1, th, 0, ZI, 1'b0, 0, 1'b0, 0, "R10", "R10");
    cyc(1'b1, th, ZI, 0, 1'b1, 5, 1'b1, 6, "R10", "R10");
  endtask

  function automatic string region_tag(input int i);
    if (i == ZI || i == ZI + P_INT) return "R6";
    if (i >= mlen) return "R11";
    if (i == mlen - 1) return "R1";
    if (i < P_INT) return "R2";
    if (i < P_INT + P_FP) return "R3";
    return "R4";
  endfunction

  task automatic sweep();
    for (int i = 0; i < NIDX; i += 2)
      rd(i, i + 1, region_tag(i), region_tag(i + 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);

    do_reset(2);  sweep();
    do_reset(3);  sweep();
    rd(LEN - 1, LEN, "R1", "R11");
    do_reset(0);  sweep();
    rd(L_INT - 1, L_INT, "R5", "R5");
    // Thread input moves outside reset: length must stay at one thread.
    cyc(1'b0, 3, 0, 0, 1'b1, P_INT + P_FP + MISC, 1'b0, 0, "R10", "R10");
    rd(P_INT + P_FP + MISC, P_INT + P_FP + MISC + 1, "R5", "R11");
    // Clear both zero registers, then read them.
    cyc(1'b0, 3, 0, 0, 1'b0, 0, 1'b1, ZI, "R10", "R10");
    cyc(1'b0, 3, 0, 0, 1'b0, 0, 1'b1, ZI + P_INT, "R10", "R10");
    rd(ZI, ZI + P_INT, "R6", "R6");
    // Set and clear singly.
    cyc(1'b0, 3, 0, 0, 1'b1, 10, 1'b1, 0, "R10", "R10");
    rd(10, 0, "R7", "R8");
    // Same-index set and clear while reading it: old value now, zero next.
    cyc(1'b0, 3, 1, 1, 1'b1, 1, 1'b1, 1, "R10", "R12");
    rd(1, 3, "R9", "R12");
    // Out-of-range writes.
    cyc(1'b0, 3, 0, 0, 1'b1, LEN - 1, 1'b1, 3, "R11", "R11");
    rd(LEN - 1, 3, "R11", "R8");
    cyc(1'b0, 3, 0, 0, 1'b1, NIDX - 1, 1'b0, 0, "R11", "R11");
    rd(NIDX - 1, 13, "R11", "R12");

    for (int n = 0; n < 6000; n++) begin
      int ai, bi, si, ci;
      bit r;
      r  = ($urandom % 250) == 0;
      ai = ($urandom % 8 == 0) ? ZI + P_INT * int'($urandom % 2) : int'($urandom % NIDX);
      bi = int'($urandom % NIDX);
      si = int'($urandom % NIDX);
      ci = ($urandom % 6 == 0) ? si : int'($urandom % NIDX);
      if (r) cur_th = int'($urandom % (MAXT + 1));
      cyc(r, cur_th, ai, bi, ($urandom % 2) == 1, si, ($urandom % 3) == 0, ci,
          r ? "R10" : tag_of(ai), r ? "R10" : tag_of(bi));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule